// File: doc/BRIEF.md
# ASID-Tagged Translation Lookaside Buffer

This block is a small fully associative cache of page translations. It is searched in parallel for a virtual page number and an address-space identifier (ASID). On a hit it returns the physical frame number and the permission code in the same cycle. It also reports a protection fault when the requested access kind is not allowed by that permission code. On a miss it raises `miss`, and the surrounding page-table walker later supplies a refill entry.

Every entry carries an ASID tag, so translations of several processes can stay resident across a context switch. An entry may also be marked global, in which case it matches any ASID. Software-visible maintenance is done by two commands. One clears the non-global entries of a single ASID. The other clears everything.

A refill goes into the slot that already holds a clashing translation, if there is one. Otherwise it goes into the lowest free slot. When no slot is free, it goes into the slot named by a round-robin pointer.

Top module: `asid_tlb`

## Requirements
- R1: An entry matches a lookup when it is valid, its VPN equals `lk_vpn`, and it is global or its ASID equals `lk_asid`. With `lk_valid` high and a match, `hit` is 1 and `pfn`/`perm` show that entry's fields in the same cycle, with no clock edge in between.
- R2: With `lk_valid` high and no matching entry, `miss` is 1 and `hit` is 0. With `lk_valid` low, both `hit` and `miss` are 0. `hit` and `miss` are never both 1.
- R3: A non-global entry never matches a lookup whose ASID differs from its tag.
- R4: A global entry matches a lookup with its VPN under any ASID.
- R5: Permission codes are 0 read-only, 1 read-write, 2 execute-only and 3 no access. Access kinds are 0 read, 1 write, 2 fetch and 3 reserved. `fault` is 1 only on a hit where the access is not allowed. Read is allowed by codes 0 and 1, write only by 1, and fetch only by 2. `fault` is 0 on a miss.
- R6: A taken refill is installed at the next clock edge. If no entry clashes with it, it goes into the lowest-numbered invalid slot. When all slots are valid, it goes into the slot named by a round-robin pointer. The pointer starts at 0 and steps by one, wrapping, only when it is used.
- R7: An entry clashes with a refill when it is valid, has the same VPN, and either of the two is global or the ASIDs are equal. A refill overwrites the lowest clashing slot and invalidates the other clashing slots, so no lookup ever matches more than one entry.
- R8: `flush_asid_en` invalidates, at the next edge, every valid non-global entry whose ASID equals `flush_asid`. Global entries and other ASIDs are kept.
- R9: `flush_all` invalidates every entry at the next edge.
- R10: A refill presented in a cycle where `flush_all` or `flush_asid_en` is high is ignored and does not move the round-robin pointer.
- R11: A synchronous active-low reset invalidates all entries and sets the round-robin pointer to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_asid | input | ASID_W | Current address-space identifier |
| lk_kind | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| hit | output | 1 | Lookup found a translation |
| miss | output | 1 | Lookup found none |
| fault | output | 1 | Hit with a disallowed access |
| pfn | output | PFN_W | Frame number of the hit (0 otherwise) |
| perm | output | 2 | Permission code of the hit (0 otherwise) |
| fill_en | input | 1 | Install a refill entry |
| fill_vpn | input | VPN_W | Refill virtual page number |
| fill_asid | input | ASID_W | Refill ASID tag |
| fill_global | input | 1 | Refill matches any ASID |
| fill_pfn | input | PFN_W | Refill frame number |
| fill_perm | input | 2 | Refill permission code |
| flush_asid_en | input | 1 | Clear non-global entries of one ASID |
| flush_asid | input | ASID_W | ASID to clear |
| flush_all | input | 1 | Clear every entry |

## Verification
Several properties are checked on every cycle by the assertions:
- a lookup never matches two entries;
- `hit` and `miss` exclude each other;
- `fault` implies `hit`;
- a cleared slot is invalid after the edge unless it is being written;
- a free-slot victim really is free;
- a refill leaves its slot valid.

Which slot gets evicted, and when, can only be shown by the bench's scenarios. The same holds for the survival of global entries across a per-ASID flush, and for the ignoring of refills during flushes. For these, the bench compares every lookup against a behavioural model through long fill sequences that wrap the round-robin pointer.

// File: rtl/tlb_pkg.sv
// Shared encodings for the translation buffer.
// Permission and access-kind codes are fixed because the bench and the
// page-table walker both rely on them.
package tlb_pkg;

    typedef enum logic [1:0] {
        PERM_RO   = 2'd0,
        PERM_RW   = 2'd1,
        PERM_XO   = 2'd2,
        PERM_NONE = 2'd3
    } perm_e;

    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_FETCH = 2'd2,
        ACC_RSVD  = 2'd3
    } acc_e;

    // True when an access of kind k is allowed by permission code p.
    function automatic logic access_ok(input logic [1:0] p, input logic [1:0] k);
        unique case (k)
            ACC_READ:  return (p == PERM_RO) || (p == PERM_RW);
            ACC_WRITE: return (p == PERM_RW);
            ACC_FETCH: return (p == PERM_XO);
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tlb_prio_enc.sv
// Lowest-index priority encoder.
// Assumes N >= 2. `idx` is 0 when no request bit is set.
module tlb_prio_enc #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     req,
    output logic [IDX_W-1:0] idx,
    output logic             any
);
    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) idx = IDX_W'(i);
        end
    end

    assign any = |req;
endmodule

// File: rtl/tlb_entry_array.sv
// Entry storage with per-entry comparators.
// Each slot holds valid, global, VPN, ASID, PFN and permission fields.
// Every slot compares itself in parallel against:
//   - the lookup key,
//   - the refill key (clash test),
//   - the flush ASID.
// Assumes a write and a clear to the same slot in one cycle resolve to the write.
module tlb_entry_array #(
    parameter int N      = 64,
    parameter int VPN_W  = 20,
    parameter int ASID_W = 8,
    parameter int PFN_W  = 20,
    parameter int IDX_W  = $clog2(N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    output logic [N-1:0]      lk_match,
    input  logic [VPN_W-1:0]  fl_vpn,
    input  logic [ASID_W-1:0] fl_asid,
    input  logic              fl_global,
    output logic [N-1:0]      fl_clash,
    input  logic [ASID_W-1:0] kill_asid,
    output logic [N-1:0]      asid_kill,
    output logic [N-1:0]      valid,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [PFN_W-1:0]  wr_pfn,
    input  logic [1:0]        wr_perm,
    input  logic [N-1:0]      clr_mask,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [PFN_W-1:0]  rd_pfn,
    output logic [1:0]        rd_perm
);
    logic [PFN_W-1:0] pfn_arr  [N];
    logic [1:0]       perm_arr [N];

    for (genvar i = 0; i < N; i++) begin : g_ent
        logic              v_q, g_q;
        logic [VPN_W-1:0]  vpn_q;
        logic [ASID_W-1:0] asid_q;
        logic [PFN_W-1:0]  pfn_q;
        logic [1:0]        perm_q;
        logic              wr_here;

        assign wr_here = wr_en && (wr_idx == IDX_W'(i));

        // Valid bit: a write sets it, a clear drops it, reset empties it.
        always_ff @(posedge clk) begin
            if (!rst_n)       v_q <= 1'b0;
            else if (wr_here) v_q <= 1'b1;
            else if (clr_mask[i]) v_q <= 1'b0;
        end

        // Payload fields: loaded on a write; they need no reset.
        always_ff @(posedge clk) begin
            if (wr_here) begin
                g_q    <= fl_global;
                vpn_q  <= fl_vpn;
                asid_q <= fl_asid;
                pfn_q  <= wr_pfn;
                perm_q <= wr_perm;
            end
        end

        assign lk_match[i]  = v_q && (vpn_q == lk_vpn) && (g_q || (asid_q == lk_asid));
        assign fl_clash[i]  = v_q && (vpn_q == fl_vpn) && (g_q || fl_global || (asid_q == fl_asid));
        assign asid_kill[i] = v_q && !g_q && (asid_q == kill_asid);
        assign valid[i]     = v_q;
        assign pfn_arr[i]   = pfn_q;
        assign perm_arr[i]  = perm_q;

        // R8/R9: a slot cleared and not rewritten is empty after the edge.
        p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !wr_here) |=> !v_q);
    end

    assign rd_pfn  = pfn_arr[rd_idx];
    assign rd_perm = perm_arr[rd_idx];
endmodule

// File: rtl/tlb_victim_sel.sv
// Chooses the slot a refill goes into.
// Order of choice: the lowest clashing slot, then the lowest invalid slot,
// then the round-robin pointer. The pointer steps only when it is used.
module tlb_victim_sel #(
    parameter int N     = 64,
    parameter int IDX_W = $clog2(N)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     valid,
    input  logic [N-1:0]     clash,
    input  logic             take,
    output logic [IDX_W-1:0] idx
);
    logic [IDX_W-1:0] clash_idx, free_idx, rr_q;
    logic             clash_any, free_any, use_rr;

    tlb_prio_enc #(.N(N), .IDX_W(IDX_W)) u_clash_enc (.req(clash),  .idx(clash_idx), .any(clash_any));
    tlb_prio_enc #(.N(N), .IDX_W(IDX_W)) u_free_enc  (.req(~valid), .idx(free_idx),  .any(free_any));

    assign use_rr = !clash_any && !free_any;
    assign idx    = clash_any ? clash_idx : (free_any ? free_idx : rr_q);

    // Round-robin pointer: steps (with wrap) only when a full buffer evicts.
    always_ff @(posedge clk) begin
        if (!rst_n) rr_q <= '0;
        else if (take && use_rr) rr_q <= (rr_q == IDX_W'(N - 1)) ? '0 : rr_q + 1'b1;
    end

    // R6: a free-slot choice really is free.
    p_free_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (free_any && !clash_any) |-> !valid[idx]);
    // R7: a clash choice really clashes.
    p_clash_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clash_any |-> clash[idx]);
endmodule

// File: rtl/asid_tlb.sv
// Fully associative, ASID-tagged translation lookaside buffer.
// Lookup results (hit, miss, fault, pfn, perm) are combinational from the
// lookup inputs and the stored entries. Refills and flushes take effect on
// the next clock edge. A refill is dropped in any cycle with a flush.
module asid_tlb #(
    parameter int ENTRIES = 64,
    parameter int VPN_W   = 20,
    parameter int ASID_W  = 8,
    parameter int PFN_W   = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              lk_valid,
    input  logic [VPN_W-1:0]  lk_vpn,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic [1:0]        lk_kind,
    output logic              hit,
    output logic              miss,
    output logic              fault,
    output logic [PFN_W-1:0]  pfn,
    output logic [1:0]        perm,
    input  logic              fill_en,
    input  logic [VPN_W-1:0]  fill_vpn,
    input  logic [ASID_W-1:0] fill_asid,
    input  logic              fill_global,
    input  logic [PFN_W-1:0]  fill_pfn,
    input  logic [1:0]        fill_perm,
    input  logic              flush_asid_en,
    input  logic [ASID_W-1:0] flush_asid,
    input  logic              flush_all
);
    import tlb_pkg::*;

    localparam int IDX_W = $clog2(ENTRIES);

    logic [ENTRIES-1:0] lk_match, fl_clash, asid_kill, valid, clr_mask, wr_onehot;
    logic [IDX_W-1:0]   hit_idx, victim_idx;
    logic               hit_any, fill_take;
    logic [PFN_W-1:0]   rd_pfn;
    logic [1:0]         rd_perm;

    assign fill_take = fill_en && !flush_all && !flush_asid_en;
    assign wr_onehot = ENTRIES'(1) << victim_idx;

    // Slots to invalidate this cycle: flush commands, or the other clashing slots of a refill.
    always_comb begin
        if (flush_all)          clr_mask = '1;
        else if (flush_asid_en) clr_mask = asid_kill;
        else if (fill_take)     clr_mask = fl_clash & ~wr_onehot;
        else                    clr_mask = '0;
    end

    tlb_entry_array #(
        .N(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W), .PFN_W(PFN_W), .IDX_W(IDX_W)
    ) u_array (
        .clk(clk), .rst_n(rst_n),
        .lk_vpn(lk_vpn), .lk_asid(lk_asid), .lk_match(lk_match),
        .fl_vpn(fill_vpn), .fl_asid(fill_asid), .fl_global(fill_global), .fl_clash(fl_clash),
        .kill_asid(flush_asid), .asid_kill(asid_kill), .valid(valid),
        .wr_en(fill_take), .wr_idx(victim_idx), .wr_pfn(fill_pfn), .wr_perm(fill_perm),
        .clr_mask(clr_mask), .rd_idx(hit_idx), .rd_pfn(rd_pfn), .rd_perm(rd_perm)
    );

    tlb_prio_enc #(.N(ENTRIES), .IDX_W(IDX_W)) u_hit_enc (
        .req(lk_match), .idx(hit_idx), .any(hit_any)
    );

    tlb_victim_sel #(.N(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .valid(valid), .clash(fl_clash),
        .take(fill_take), .idx(victim_idx)
    );

    // Lookup outputs: hit/miss classification, payload and protection check.
    always_comb begin
        hit   = lk_valid && hit_any;
        miss  = lk_valid && !hit_any;
        pfn   = hit ? rd_pfn  : '0;
        perm  = hit ? rd_perm : '0;
        fault = hit && !access_ok(rd_perm, lk_kind);
    end

    // R7: at most one entry ever matches a lookup key.
    p_single_match_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_match));
    // R2: hit and miss exclude each other.
    p_hit_miss_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit && miss));
    // R5: a fault only comes with a hit.
    p_fault_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> hit);
    // R9: flush-all leaves nothing valid.
    p_flush_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        flush_all |=> (valid == '0));
    // R6: a taken refill leaves its slot valid.
    p_fill_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill_take |=> valid[$past(victim_idx)]);
endmodule

// File: tb/asid_tlb_tb.sv
`timescale 1ns/1ps
module asid_tlb_tb;
    localparam int N = 64, VW = 20, AW = 8, PW = 20;

    logic clk = 0, rst_n = 0;
    logic lk_valid = 0; logic [VW-1:0] lk_vpn = 0; logic [AW-1:0] lk_asid = 0; logic [1:0] lk_kind = 0;
    logic hit, miss, fault; logic [PW-1:0] pfn; logic [1:0] perm;
    logic fill_en = 0; logic [VW-1:0] fill_vpn = 0; logic [AW-1:0] fill_asid = 0; logic fill_global = 0;
    logic [PW-1:0] fill_pfn = 0; logic [1:0] fill_perm = 0;
    logic flush_asid_en = 0; logic [AW-1:0] flush_asid = 0; logic flush_all = 0;

    always #2.5 clk = ~clk;

    asid_tlb #(.ENTRIES(N), .VPN_W(VW), .ASID_W(AW), .PFN_W(PW)) u_dut (.*);

    // Behavioural reference state.
    bit        m_v [N]; bit m_g [N];
    int        m_vpn [N]; int m_asid [N]; int m_pfn [N]; int m_perm [N];
    int        m_rr;
    int        checks = 0, errors = 0;
    string     req = "R11";

    task automatic chk(string what, longint act, longint exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic bit allowed(int p, int k);
        if (k == 0) return p == 0 || p == 1;
        if (k == 1) return p == 1;
        if (k == 2) return p == 2;
        return 0;
    endfunction

    // Compare the combinational lookup outputs against the model.
    task automatic compare();
        int mi = -1;
        for (int i = 0; i < N; i++)
            if (mi < 0 && m_v[i] && m_vpn[i] == int'(lk_vpn) && (m_g[i] || m_asid[i] == int'(lk_asid))) mi = i;
        if (!lk_valid) begin
            chk("hit idle", hit, 0); chk("miss idle", miss, 0);
        end else begin
            chk("hit", hit, mi >= 0); chk("miss", miss, mi < 0);
            chk("fault", fault, mi >= 0 && !allowed(m_perm[mi], lk_kind));
            if (mi >= 0) begin chk("pfn", pfn, m_pfn[mi]); chk("perm", perm, m_perm[mi]); end
        end
    endtask

    // Apply this cycle's commands to the model.
    task automatic model_edge();
        if (!rst_n) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
            m_rr = 0;
        end else if (flush_all) begin
            for (int i = 0; i < N; i++) m_v[i] = 0;
        end else if (flush_asid_en) begin
            for (int i = 0; i < N; i++) if (m_v[i] && !m_g[i] && m_asid[i] == int'(flush_asid)) m_v[i] = 0;
        end else if (fill_en) begin
            int t = -1;
            for (int i = 0; i < N; i++)
                if (m_v[i] && m_vpn[i] == int'(fill_vpn) && (m_g[i] || fill_global || m_asid[i] == int'(fill_asid))) begin
                    if (t < 0) t = i; else m_v[i] = 0;
                end
            if (t < 0) for (int i = 0; i < N; i++) if (t < 0 && !m_v[i]) t = i;
            if (t < 0) begin t = m_rr; m_rr = (m_rr + 1) % N; end
            m_v[t] = 1; m_g[t] = fill_global; m_vpn[t] = fill_vpn; m_asid[t] = fill_asid;
            m_pfn[t] = fill_pfn; m_perm[t] = fill_perm;
        end
    endtask

    // One cycle: inputs already set after a falling edge.
    task automatic cyc();
        #1 compare();
        @(posedge clk); model_edge();
        @(negedge clk);
        fill_en = 0; flush_all = 0; flush_asid_en = 0;
    endtask

    task automatic look(int v, int a, int k);
        lk_valid = 1; lk_vpn = VW'(v); lk_asid = AW'(a); lk_kind = 2'(k); cyc();
    endtask

    task automatic fill(int v, int a, bit g, int p, int pr);
        fill_en = 1; fill_vpn = VW'(v); fill_asid = AW'(a); fill_global = g;
        fill_pfn = PW'(p); fill_perm = 2'(pr); lk_valid = 0; cyc();
    endtask

    initial begin
        #(5.0 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk); cyc(); cyc(); rst_n = 1;
        // R11: empty after reset; R2 idle outputs.
        req = "R11"; look(5, 1, 0); look(0, 0, 0);
        req = "R2"; lk_valid = 0; cyc();
        // R1 basic hit, R3 isolation.
        req = "R1"; fill(10, 1, 0, 'h111, 1); fill(11, 1, 0, 'h222, 0);
        look(10, 1, 0); look(11, 1, 0);
        req = "R3"; look(10, 2, 0); look(11, 7, 0);
        // R4 global.
        req = "R4"; fill(20, 3, 1, 'h333, 1); look(20, 3, 0); look(20, 9, 1); look(20, 200, 0);
        // R5 permissions.
        req = "R5";
        for (int p = 0; p < 4; p++) fill(30 + p, 1, 0, 'h400 + p, p);
        for (int p = 0; p < 4; p++) for (int k = 0; k < 4; k++) look(30 + p, 1, k);
        look(99, 1, 1);
        // R7 overwrite and clash clean-up.
        req = "R7"; fill(10, 1, 0, 'h999, 1); look(10, 1, 0);
        fill(40, 1, 0, 'h41, 1); fill(40, 2, 0, 'h42, 1); fill(40, 5, 1, 'h4f, 0);
        look(40, 1, 0); look(40, 2, 0); look(40, 6, 0);
        // R8 per-ASID flush keeps globals.
        req = "R8"; fill(50, 4, 0, 'h50, 1); flush_asid_en = 1; flush_asid = 1; lk_valid = 0; cyc();
        look(11, 1, 0); look(20, 3, 0); look(50, 4, 0); look(40, 1, 0);
        // R10 refill dropped during flushes.
        req = "R10"; flush_asid_en = 1; flush_asid = 77; fill(60, 4, 0, 'h60, 1);
        look(60, 4, 0);
        flush_all = 1; fill(61, 4, 0, 'h61, 1); look(61, 4, 0);
        // R9 flush all.
        req = "R9"; look(20, 3, 0); look(50, 4, 0);
        // R6 fill beyond capacity and wrap the pointer.
        req = "R6";
        for (int i = 0; i < N + 70; i++) fill(1000 + i, i % 3, 0, 'h8000 + i, 1);
        for (int i = 0; i < N + 70; i++) look(1000 + i, i % 3, 0);
        // Mixed traffic over a small key space.
        req = "R1";
        for (int i = 0; i < 600; i++) begin
            int op = $urandom_range(0, 19);
            if (op == 0) begin flush_asid_en = 1; flush_asid = AW'($urandom_range(0, 3)); end
            else if (op == 1 && i % 7 == 0) flush_all = 1;
            else if (op < 9) begin
                fill_en = 1; fill_vpn = VW'($urandom_range(0, 40)); fill_asid = AW'($urandom_range(0, 3));
                fill_global = ($urandom_range(0, 5) == 0); fill_pfn = PW'($urandom); fill_perm = 2'($urandom_range(0, 3));
            end
            lk_valid = ($urandom_range(0, 4) != 0); lk_vpn = VW'($urandom_range(0, 40));
            lk_asid = AW'($urandom_range(0, 3)); lk_kind = 2'($urandom_range(0, 3));
            cyc();
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule